// File: doc/BRIEF.md
# Phase Current Table Sequential Loader

This block keeps the magnitude table that a two-phase microstepping driver reads at each of its 64 step angles. A full electrical cycle has 64 steps, and each phase has its own 64-entry table. The table is symmetric: one quadrant of one phase holds 16 distinct 6-bit magnitudes, and every other position in both tables repeats one of them. Software changes the profile through one load port. Each accepted load value goes into the next quadrant slot and is copied at once into all eight table positions that slot stands for.

A pointer-control state machine picks the slot. It has two states, `ST_ARMED` and `ST_FULL`. In `ST_ARMED` the block accepts load writes at the current pointer. On the transition "advance", an accepted write at pointer k < 15 moves the pointer to k+1. On the transition "saturate", an accepted write at pointer 15 moves the machine to `ST_FULL`, where load writes are dropped. On the transition "re-arm", a valid write to any other register address returns the machine to `ST_ARMED` with the pointer at 0. This happens from either state. Reset enters `ST_ARMED` at pointer 0 and loads a default sine quadrant. The read port is combinational and indexed by step number. The microstep sequencer that drives the step number lies outside this block.

Top module: `ptl_loader`

## Requirements
- R1: After reset, quadrant slot i (0..15) holds round(63·sin((2i+1)·π/64)), which gives 3,9,15,21,27,32,38,42,47,51,54,57,59,61,62,63. The pointer is at slot 0.
- R2: The phase A magnitude at step n equals slot n[3:0] when n[4]=0, and slot 15−n[3:0] when n[4]=1. Slot i therefore appears at steps i, 31−i, 32+i and 63−i.
- R3: The phase B magnitude at step n equals the phase A magnitude at step (n+16) mod 64.
- R4: A load write (wr_valid=1, wr_addr=2'b11) in state ST_ARMED puts wr_data into the slot at the pointer, which updates all eight positions of that slot. The next load write goes to the following slot.
- R5: A valid write with wr_addr of 2'b00, 2'b01 or 2'b10 leaves the table unchanged and returns the pointer to slot 0.
- R6: After the load into slot 15, further load writes are ignored until a re-arm.
- R7: While wr_valid is low, neither the table nor the pointer changes, whatever wr_addr and wr_data carry.
- R8: rd_mag_a and rd_mag_b follow rd_step combinationally. A load becomes visible on the read port after the clock edge that accepts it.
- R9: A re-arm from ST_FULL lets load writes be accepted again, starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address; 2'b11 selects the table load port |
| wr_data | input | 6 | Magnitude value for a table load |
| rd_step | input | 6 | Step angle number to look up |
| rd_mag_a | output | 6 | Phase A magnitude at rd_step |
| rd_mag_b | output | 6 | Phase B magnitude at rd_step |

## Verification
The embedded assertions check the pointer rules on every cycle: a re-arm returns the pointer to slot 0, an accepted load advances the pointer by one, a load at slot 15 reaches ST_FULL, ST_FULL holds until a re-arm, and an idle bus freezes both the pointer and every table entry. The per-cycle properties cannot show that values reach the right mirrored positions, that phase B keeps its 16-step offset, or what the default contents are. The directed scenarios therefore sweep all 64 steps of both phases against a quadrant model. They do this after reset, after partial, interrupted, full and overflowing loads, and after a re-arm from the full state.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    localparam int PTL_MAG_W  = 6;
    localparam int PTL_STEP_W = 6;
    localparam int PTL_IDX_W  = PTL_STEP_W - 2;
    localparam int PTL_SLOTS  = 1 << PTL_IDX_W;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_FULL  = 1'b1
    } ld_state_t;

    // quadrant slot that a phase A step position mirrors
    function automatic logic [PTL_IDX_W-1:0] slot_of_step(input logic [PTL_STEP_W-1:0] step);
        logic [PTL_IDX_W-1:0] low;
        low = step[PTL_IDX_W-1:0];
        return step[PTL_IDX_W] ? ~low : low;
    endfunction

    // default sine quadrant, sampled at half-step offsets
    function automatic logic [PTL_MAG_W-1:0] default_mag(input logic [PTL_IDX_W-1:0] slot);
        logic [PTL_MAG_W-1:0] m;
        unique case (slot)
            4'd0:  m = 6'd3;
            4'd1:  m = 6'd9;
            4'd2:  m = 6'd15;
            4'd3:  m = 6'd21;
            4'd4:  m = 6'd27;
            4'd5:  m = 6'd32;
            4'd6:  m = 6'd38;
            4'd7:  m = 6'd42;
            4'd8:  m = 6'd47;
            4'd9:  m = 6'd51;
            4'd10: m = 6'd54;
            4'd11: m = 6'd57;
            4'd12: m = 6'd59;
            4'd13: m = 6'd61;
            4'd14: m = 6'd62;
            default: m = 6'd63;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ptl_ptr_fsm.sv
module ptl_ptr_fsm
    import ptl_pkg::*;
#(
    parameter int IDX_W    = PTL_IDX_W,
    parameter int ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    ld_state_t        state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             load_req, rearm;

    always_comb begin
        load_req = wr_valid && (wr_addr == LOAD_ADDR);
        rearm    = wr_valid && (wr_addr != LOAD_ADDR);
    end

    // next-state and pointer logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_ARMED: begin
                if (rearm) begin
                    ptr_d = '0;
                end else if (load_req) begin
                    if (ptr_q == LAST_IDX) begin
                        state_d = ST_FULL;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
            end
            ST_FULL: begin
                if (rearm) begin
                    state_d = ST_ARMED;
                    ptr_d   = '0;
                end
            end
            default: begin
                state_d = ST_ARMED;
                ptr_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        wr_en  = load_req && (state_q == ST_ARMED);
        wr_idx = ptr_q;
    end

    assert_rearm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (ptr_q == '0) && (state_q == ST_ARMED));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_q != LAST_IDX) |=> (ptr_q == IDX_W'($past(ptr_q) + 1'b1)));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_q == LAST_IDX) |=> (state_q == ST_FULL));

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !rearm) |=> (state_q == ST_FULL));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(ptr_q) && $stable(state_q)));

endmodule

// File: rtl/ptl_store.sv
module ptl_store
    import ptl_pkg::*;
#(
    parameter int MAG_W  = PTL_MAG_W,
    parameter int STEP_W = PTL_STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STEP_W-3:0] wr_idx,
    input  logic [MAG_W-1:0]  wr_data,
    input  logic [STEP_W-1:0] rd_step,
    output logic [MAG_W-1:0]  rd_mag_a,
    output logic [MAG_W-1:0]  rd_mag_b
);

    localparam int STEPS   = 1 << STEP_W;
    localparam int QUARTER = STEPS / 4;

    logic [MAG_W-1:0] tbl_a [STEPS];
    logic [MAG_W-1:0] tbl_b [STEPS];

    for (genvar p = 0; p < STEPS; p++) begin : g_pos
        localparam logic [STEP_W-3:0] SLOT_A = slot_of_step(STEP_W'(p));
        localparam logic [STEP_W-3:0] SLOT_B = slot_of_step(STEP_W'((p + QUARTER) % STEPS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_a[p] <= default_mag(SLOT_A);
            end else if (wr_en && wr_idx == SLOT_A) begin
                tbl_a[p] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_b[p] <= default_mag(SLOT_B);
            end else if (wr_en && wr_idx == SLOT_B) begin
                tbl_b[p] <= wr_data;
            end
        end

        assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(tbl_a[p]));

        assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(tbl_b[p]));
    end

    always_comb begin
        rd_mag_a = tbl_a[rd_step];
        rd_mag_b = tbl_b[rd_step];
    end

endmodule

// File: rtl/ptl_loader.sv
module ptl_loader
    import ptl_pkg::*;
#(
    parameter int MAG_W  = PTL_MAG_W,
    parameter int STEP_W = PTL_STEP_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MAG_W-1:0]  wr_data,
    input  logic [STEP_W-1:0] rd_step,
    output logic [MAG_W-1:0]  rd_mag_a,
    output logic [MAG_W-1:0]  rd_mag_b
);

    localparam int IDX_W = STEP_W - 2;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    ptl_ptr_fsm #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx)
    );

    ptl_store #(
        .MAG_W  (MAG_W),
        .STEP_W (STEP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_step  (rd_step),
        .rd_mag_a (rd_mag_a),
        .rd_mag_b (rd_mag_b)
    );

    // a load is accepted only on a load-port strobe
    assert_load_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_valid && wr_addr == '1));

endmodule

// File: tb/tb_ptl_loader.sv
`timescale 1ns/10ps
module tb_ptl_loader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [1:0] wr_addr = 2'b00;
    logic [5:0] wr_data = 6'd0;
    logic [5:0] rd_step = 6'd0;
    logic [5:0] rd_mag_a, rd_mag_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [5:0] ref_q [16];
    int ref_ptr;

    always #2 clk = ~clk;

    ptl_loader dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_step  (rd_step),
        .rd_mag_a (rd_mag_a),
        .rd_mag_b (rd_mag_b)
    );

    function automatic logic [5:0] exp_a(input int s);
        int lo;
        lo = s % 16;
        return ((s / 16) % 2 == 1) ? ref_q[15 - lo] : ref_q[lo];
    endfunction

    task automatic ref_reset();
        ref_q = '{6'd3, 6'd9, 6'd15, 6'd21, 6'd27, 6'd32, 6'd38, 6'd42,
                  6'd47, 6'd51, 6'd54, 6'd57, 6'd59, 6'd61, 6'd62, 6'd63};
        ref_ptr = 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sweep all 64 steps of both phases (R2 mapping, R3 offset, R8 combinational read)
    task automatic check_table(input string req);
        @(negedge clk);
        for (int s = 0; s < 64; s++) begin
            rd_step = 6'(s);
            #0.01;
            check({req, "/R2/R8"}, $sformatf("phase A step %0d", s), int'(rd_mag_a), int'(exp_a(s)));
            check({req, "/R3"}, $sformatf("phase B step %0d", s), int'(rd_mag_b), int'(exp_a((s + 16) % 64)));
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        if (a == 2'b11) begin
            if (ref_ptr < 16) begin
                ref_q[ref_ptr] = d;
                ref_ptr++;
            end
        end else begin
            ref_ptr = 0;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        ref_reset();
        check_table("R1");
    endtask

    task automatic t_partial();
        for (int k = 0; k < 5; k++) do_write(2'b11, 6'(10 + k));
        check_table("R4");
    endtask

    task automatic t_rearm();
        do_write(2'b01, 6'd33);
        check_table("R5");
        do_write(2'b11, 6'd44);
        check_table("R5 pointer at slot 0");
        do_write(2'b00, 6'd1);
        do_write(2'b10, 6'd2);
        do_write(2'b11, 6'd5);
        check_table("R5 after addr 0/2");
    endtask

    task automatic t_full_overflow();
        do_write(2'b00, 6'd0);
        for (int k = 0; k < 16; k++) do_write(2'b11, 6'(63 - 3 * k));
        check_table("R4 full load");
        for (int k = 0; k < 3; k++) do_write(2'b11, 6'd0);
        check_table("R6 overflow ignored");
    endtask

    task automatic t_idle();
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            wr_addr = 2'(k);
            wr_data = 6'(k * 11);
            @(negedge clk);
        end
        check_table("R7");
    endtask

    task automatic t_rearm_full();
        do_write(2'b10, 6'd9);
        do_write(2'b11, 6'd17);
        do_write(2'b11, 6'd18);
        check_table("R9");
    endtask

    initial begin
        ref_reset();
        repeat (3) @(negedge clk);
        // reset state must already be visible on the read port (R1)
        rd_step = 6'd0;
        #0.01;
        check("R1", "step 0 during reset", int'(rd_mag_a), 3);
        rst_n = 1'b1;
        t_reset();
        t_partial();
        t_rearm();
        t_full_overflow();
        t_idle();
        t_rearm_full();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule